// File: doc/BRIEF.md
# Word-Clock-Framed Stereo Serial Audio Receiver

This block takes a stereo audio stream carried on one serial data line, framed only by a word clock at the sample rate Fs, and turns it into parallel 24-bit left and right samples. No bit clock travels with the data: the block runs from a fast system clock held at exactly 768 times Fs, and derives its own bit-clock timing from that clock. The rising edge of the word clock opens each sample period and starts the left channel. The right channel starts exactly half a sample period later, whatever the word-clock duty cycle.

Samples are two's complement and sent MSB first, with 24 significant bits per channel. A format input picks the slot length per channel: 32 bits, with a bit period of 12 system clocks and 8 trailing bits that carry no data, or 24 bits, with a bit period of 16 system clocks. Each bit is sampled in the middle of its period, which matches the falling edge of a bit clock whose rising edge lines up with the word-clock rise. A new format takes effect at the next word-clock rise. When the last right-channel bit arrives, both outputs are updated together and a one-cycle valid strobe is raised. A sticky flag records any word-clock period that differs from 768 system clocks.

Top module: `wcsr_rx`

## Requirements
- R1: While reset is asserted, and after it is released, left_o, right_o, valid_o and frame_err_o are all 0 until the block acts on a frame.
- R2: With fmt_i = 1 each channel slot is 24 bits of 16 system clocks each. The left slot starts at the word-clock rise and the right slot starts 384 system clocks after it.
- R3: With fmt_i = 0 each channel slot is 32 bits of 12 system clocks each. The right slot starts 384 system clocks after the rise. Bits 24 to 31 of each slot have no effect on the outputs.
- R4: The first bit of each slot becomes bit 23 (the MSB) of that channel's output and the 24th bit becomes bit 0. Two's-complement codes such as 24'h800000 and 24'h7FFFFF pass through unchanged.
- R5: The right-channel data is decoded correctly for any word-clock high time from 3 to 765 system clocks. The falling edge of the word clock is never used.
- R6: After the 24th right-channel bit, left_o and right_o are updated in the same cycle and valid_o is high for exactly one cycle. This happens once per complete frame, and the outputs hold their values at all other times.
- R7: A change on fmt_i during a frame has no effect on that frame. It is applied at the next word-clock rise.
- R8: frame_err_o goes to 1 when a word-clock rise follows the previous rise by any number of system clocks other than 768. The first rise after reset is not checked. Once set, the flag stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, 768 times the sample rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wclk_i | input | 1 | Word clock; a rising edge starts a sample period |
| sdata_i | input | 1 | Serial audio data, MSB first |
| fmt_i | input | 1 | Slot format: 0 = 32-bit slots, 1 = 24-bit slots |
| left_o | output | 24 | Last captured left sample |
| right_o | output | 24 | Last captured right sample |
| valid_o | output | 1 | One-cycle strobe when both samples are updated |
| frame_err_o | output | 1 | Sticky flag for a wrong word-clock period |

## Verification
All timing is counted from the system-clock edge that first sees a word-clock rise driven by the bench. Two synchroniser stages and one edge-detect stage pass before the bit counters restart. The 24th right bit is sampled 666 clocks later in the 32-bit format and 760 clocks later in the 24-bit format, so valid_o and the new samples appear about 669 or 763 clocks after the rise. The error flag follows a bad rise within 3 clocks. The bench therefore checks samples, the count of valid pulses and the error flag only after all 768 clocks of a frame have been driven, at a falling clock edge. At that point the samples for the frame have settled and valid_o must already be low again.

// File: rtl/wcsr_pkg.sv
package wcsr_pkg;

   // Slot qualifiers produced by the timebase for each bit strobe
   typedef struct packed {
      logic take_l;   // strobe belongs to a left data bit
      logic take_r;   // strobe belongs to a right data bit
      logic last_r;   // strobe is the final right data bit
   } wcsr_slot_t;

   // System clocks per serial bit for a given slot length
   function automatic int unsigned clocks_per_bit(input int unsigned per_fs,
                                                  input int unsigned slot_bits);
      return per_fs / (2 * slot_bits);
   endfunction

endpackage

// File: rtl/wcsr_sync.sv
module wcsr_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("wcsr_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < WIDTH; g++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) chain_q <= '0;
         else         chain_q <= {chain_q[STAGES-2:0], d_i[g]};
      end
      assign q_o[g] = chain_q[STAGES-1];
   end

endmodule

// File: rtl/wcsr_timebase.sv
module wcsr_timebase
   import wcsr_pkg::*;
#(
   parameter int unsigned SYS_PER_FS  = 768,
   parameter int unsigned SLOT_WIDE   = 32,
   parameter int unsigned SLOT_NARROW = 24,
   parameter int unsigned SAMPLE_W    = 24
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       rise_i,
   input  logic       fmt_i,
   output logic       strobe_o,
   output wcsr_slot_t slot_o
);

   localparam int unsigned DIV_WIDE   = clocks_per_bit(SYS_PER_FS, SLOT_WIDE);
   localparam int unsigned DIV_NARROW = clocks_per_bit(SYS_PER_FS, SLOT_NARROW);
   localparam int unsigned DIV_MAX    = (DIV_WIDE > DIV_NARROW) ? DIV_WIDE : DIV_NARROW;
   localparam int unsigned DIV_W      = $clog2(DIV_MAX);
   localparam int unsigned IDLE_BIT   = 2 * SLOT_WIDE;
   localparam int unsigned BIT_W      = $clog2(IDLE_BIT + 1);

   if (SYS_PER_FS % (2 * SLOT_WIDE) != 0) begin : g_bad_wide
      $error("wcsr_timebase: SYS_PER_FS must divide into wide-slot bits");
   end
   if (SYS_PER_FS % (2 * SLOT_NARROW) != 0) begin : g_bad_narrow
      $error("wcsr_timebase: SYS_PER_FS must divide into narrow-slot bits");
   end
   if (SLOT_NARROW > SLOT_WIDE || SAMPLE_W > SLOT_NARROW) begin : g_bad_slots
      $error("wcsr_timebase: need SAMPLE_W <= SLOT_NARROW <= SLOT_WIDE");
   end
   if (DIV_WIDE < 4 || DIV_NARROW < 4) begin : g_bad_div
      $error("wcsr_timebase: bit period too short for mid-bit sampling");
   end

   logic             narrow_q;
   logic [DIV_W-1:0] div_q;
   logic [BIT_W-1:0] bit_q;
   logic [DIV_W-1:0] div_last, div_mid;
   logic [BIT_W-1:0] slot_bits, frame_bits;
   logic             running;

   always_comb begin
      if (narrow_q) begin
         div_last   = DIV_W'(DIV_NARROW - 1);
         div_mid    = DIV_W'(DIV_NARROW / 2);
         slot_bits  = BIT_W'(SLOT_NARROW);
         frame_bits = BIT_W'(2 * SLOT_NARROW);
      end else begin
         div_last   = DIV_W'(DIV_WIDE - 1);
         div_mid    = DIV_W'(DIV_WIDE / 2);
         slot_bits  = BIT_W'(SLOT_WIDE);
         frame_bits = BIT_W'(2 * SLOT_WIDE);
      end
   end

   assign running = (bit_q < frame_bits);

   // The word-clock rise restarts the bit timing and latches the format
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         narrow_q <= 1'b0;
         div_q    <= '0;
         bit_q    <= BIT_W'(IDLE_BIT);
      end else if (rise_i) begin
         narrow_q <= fmt_i;
         div_q    <= '0;
         bit_q    <= '0;
      end else if (running) begin
         if (div_q == div_last) begin
            div_q <= '0;
            bit_q <= bit_q + 1'b1;
         end else begin
            div_q <= div_q + 1'b1;
         end
      end
   end

   // Mid-period sample point stands in for the bit-clock falling edge
   assign strobe_o = running && (div_q == div_mid);

   always_comb begin
      slot_o.take_l = (bit_q < BIT_W'(SAMPLE_W));
      slot_o.take_r = (bit_q >= slot_bits) && (bit_q < slot_bits + BIT_W'(SAMPLE_W));
      slot_o.last_r = (bit_q == slot_bits + BIT_W'(SAMPLE_W - 1));
   end

endmodule

// File: rtl/wcsr_period_mon.sv
module wcsr_period_mon #(
   parameter int unsigned SYS_PER_FS = 768
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic rise_i,
   output logic err_o
);

   localparam int unsigned CNT_W = $clog2(SYS_PER_FS) + 1;
   localparam logic [CNT_W-1:0] CNT_GOOD = CNT_W'(SYS_PER_FS - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             armed_q;

   // Counter saturates so a lost word clock still reads as a wrong period
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q   <= '1;
         armed_q <= 1'b0;
         err_o   <= 1'b0;
      end else if (rise_i) begin
         cnt_q   <= '0;
         armed_q <= 1'b1;
         if (armed_q && cnt_q != CNT_GOOD) err_o <= 1'b1;
      end else if (cnt_q != '1) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/wcsr_capture.sv
module wcsr_capture
   import wcsr_pkg::*;
#(
   parameter int unsigned SAMPLE_W = 24
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                strobe_i,
   input  wcsr_slot_t          slot_i,
   input  logic                bit_i,
   output logic [SAMPLE_W-1:0] left_o,
   output logic [SAMPLE_W-1:0] right_o,
   output logic                valid_o
);

   logic [SAMPLE_W-1:0] sh_l_q;
   logic [SAMPLE_W-1:0] sh_r_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sh_l_q <= '0;
         sh_r_q <= '0;
      end else if (strobe_i) begin
         if (slot_i.take_l) sh_l_q <= {sh_l_q[SAMPLE_W-2:0], bit_i};
         if (slot_i.take_r) sh_r_q <= {sh_r_q[SAMPLE_W-2:0], bit_i};
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         left_o  <= '0;
         right_o <= '0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (strobe_i && slot_i.last_r) begin
            left_o  <= sh_l_q;
            right_o <= {sh_r_q[SAMPLE_W-2:0], bit_i};
            valid_o <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/wcsr_rx.sv
module wcsr_rx
   import wcsr_pkg::*;
#(
   parameter int unsigned SYS_PER_FS  = 768,
   parameter int unsigned SLOT_WIDE   = 32,
   parameter int unsigned SLOT_NARROW = 24,
   parameter int unsigned SAMPLE_W    = 24,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                wclk_i,
   input  logic                sdata_i,
   input  logic                fmt_i,
   output logic [SAMPLE_W-1:0] left_o,
   output logic [SAMPLE_W-1:0] right_o,
   output logic                valid_o,
   output logic                frame_err_o
);

   localparam int unsigned N_SYNC = 3;

   logic [N_SYNC-1:0] raw_w, sync_w;
   logic              wclk_s, sdata_s, fmt_s;
   logic              wclk_prev_q;
   logic              rise_w;
   logic              strobe_w;
   wcsr_slot_t        slot_w;
   logic              last_w;

   assign raw_w = {fmt_i, sdata_i, wclk_i};

   wcsr_sync #(
      .WIDTH  (N_SYNC),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (raw_w),
      .q_o    (sync_w)
   );

   assign {fmt_s, sdata_s, wclk_s} = sync_w;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) wclk_prev_q <= 1'b0;
      else         wclk_prev_q <= wclk_s;
   end

   assign rise_w = wclk_s && !wclk_prev_q;

   wcsr_timebase #(
      .SYS_PER_FS  (SYS_PER_FS),
      .SLOT_WIDE   (SLOT_WIDE),
      .SLOT_NARROW (SLOT_NARROW),
      .SAMPLE_W    (SAMPLE_W)
   ) u_timebase (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .rise_i   (rise_w),
      .fmt_i    (fmt_s),
      .strobe_o (strobe_w),
      .slot_o   (slot_w)
   );

   assign last_w = slot_w.last_r;

   wcsr_period_mon #(
      .SYS_PER_FS (SYS_PER_FS)
   ) u_period (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .rise_i (rise_w),
      .err_o  (frame_err_o)
   );

   wcsr_capture #(
      .SAMPLE_W (SAMPLE_W)
   ) u_capture (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .strobe_i (strobe_w),
      .slot_i   (slot_w),
      .bit_i    (sdata_s),
      .left_o   (left_o),
      .right_o  (right_o),
      .valid_o  (valid_o)
   );

endmodule

// File: rtl/wcsr_rx_chk.sv
module wcsr_rx_chk #(
   parameter int unsigned SAMPLE_W = 24
) (
   input logic                clk_i,
   input logic                rst_ni,
   input logic                rise_w,
   input logic                strobe_w,
   input logic                last_w,
   input logic [SAMPLE_W-1:0] left_o,
   input logic [SAMPLE_W-1:0] right_o,
   input logic                valid_o,
   input logic                frame_err_o
);

   // R6: valid is a single-cycle pulse
   p_valid_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |=> !valid_o);

   // R6: samples only move together with valid
   p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_o |-> ($stable(left_o) && $stable(right_o)));

   // R6: valid follows the final right-channel bit strobe
   p_valid_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> $past(strobe_w && last_w));

   // R8: the error flag is sticky
   p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frame_err_o |=> frame_err_o);

   // R8: the error flag only rises after a word-clock rise
   p_err_on_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(frame_err_o) |-> $past(rise_w));

   // R5: a word-clock rise never coincides with a bit strobe in the next cycle
   p_no_strobe_after_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_w |=> !strobe_w);

endmodule

bind wcsr_rx wcsr_rx_chk #(
   .SAMPLE_W (SAMPLE_W)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .rise_w      (rise_w),
   .strobe_w    (strobe_w),
   .last_w      (last_w),
   .left_o      (left_o),
   .right_o     (right_o),
   .valid_o     (valid_o),
   .frame_err_o (frame_err_o)
);

// File: tb/wcsr_rx_bench.sv
module wcsr_rx_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wclk = 1'b0;
   logic        sdata = 1'b0;
   logic        fmt = 1'b0;
   logic [23:0] left, right;
   logic        valid, ferr;

   int unsigned total = 0;
   int unsigned bad = 0;
   int unsigned vcnt = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   wcsr_rx u_wcsr_rx (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .wclk_i      (wclk),
      .sdata_i     (sdata),
      .fmt_i       (fmt),
      .left_o      (left),
      .right_o     (right),
      .valid_o     (valid),
      .frame_err_o (ferr)
   );

   always @(posedge clk) if (valid) vcnt <= vcnt + 1;

   // {fmt, high time, left, right, don't-care fill}
   localparam logic [59:0] VEC [7] = '{
      {1'b0, 10'd384, 24'h123456, 24'hABCDEF, 1'b0},
      {1'b0, 10'd384, 24'h800000, 24'h7FFFFF, 1'b1},
      {1'b1, 10'd384, 24'hFFFFFF, 24'h000001, 1'b0},
      {1'b1, 10'd3,   24'h5A5A5A, 24'hA5A5A5, 1'b1},
      {1'b0, 10'd765, 24'h000000, 24'hFFFFFF, 1'b1},
      {1'b1, 10'd765, 24'hC3C3C3, 24'h3C3C3C, 1'b0},
      {1'b0, 10'd3,   24'h0F0F0F, 24'hF0F0F0, 1'b1}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Drive one sample period; fmt pin switches to pin_after from cycle sw on
   task automatic play(input logic enc_fmt, input logic pin_after, input int unsigned sw,
                       input int unsigned hi, input int unsigned period,
                       input logic [23:0] l, input logic [23:0] r, input logic fill);
      int unsigned div, slot;
      div  = enc_fmt ? 16 : 12;
      slot = enc_fmt ? 24 : 32;
      for (int unsigned c = 0; c < period; c++) begin
         int unsigned k, pos;
         logic [23:0] val;
         @(negedge clk);
         wclk = (c < hi);
         fmt  = (c < sw) ? enc_fmt : pin_after;
         k = c / div;
         if (k < slot) begin pos = k;        val = l; end
         else          begin pos = k - slot; val = r; end
         sdata = (pos < 24) ? val[23 - pos] : fill;
      end
   endtask

   task automatic apply_reset();
      @(negedge clk);
      rst_n = 1'b0;
      wclk  = 1'b0;
      repeat (5) @(negedge clk);
      check("R1 left in reset", 32'(left), 32'h0);
      check("R1 right in reset", 32'(right), 32'h0);
      check("R1 valid in reset", 32'(valid), 32'h0);
      check("R1 err in reset", 32'(ferr), 32'h0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 err after release", 32'(ferr), 32'h0);
   endtask

   initial begin
      int unsigned v0;
      apply_reset();
      repeat (20) @(negedge clk);

      // Table of frames, each checked after all its clocks are driven
      foreach (VEC[i]) begin
         logic [59:0] v;
         v  = VEC[i];
         v0 = vcnt;
         play(v[59], v[59], 768, 32'(v[58:49]), 768, v[48:25], v[24:1], v[0]);
         check(v[59] ? "R2 R4 left" : "R3 R4 left", 32'(left), 32'(v[48:25]));
         check(v[58:49] != 10'd384 ? "R5 right" : "R4 right", 32'(right), 32'(v[24:1]));
         check("R6 one valid per frame", vcnt - v0, 32'd1);
         check("R6 valid low at frame end", 32'(valid), 32'h0);
         check("R8 no error on 768 period", 32'(ferr), 32'h0);
      end

      // R7: fmt pin moves to 1 mid-frame; this frame still uses 32-bit slots
      v0 = vcnt;
      play(1'b0, 1'b1, 200, 384, 768, 24'h6B1C2D, 24'h94E3D2, 1'b1);
      check("R7 left keeps old format", 32'(left), 32'h6B1C2D);
      check("R7 right keeps old format", 32'(right), 32'h94E3D2);
      check("R7 one valid", vcnt - v0, 32'd1);
      play(1'b1, 1'b1, 768, 384, 768, 24'h2468AC, 24'hFDB975, 1'b0);
      check("R7 left new format", 32'(left), 32'h2468AC);
      check("R7 right new format", 32'(right), 32'hFDB975);

      // R8: a short period, then a normal frame whose rise reveals it
      play(1'b0, 1'b0, 768, 384, 700, 24'h111111, 24'h222222, 1'b0);
      check("R8 no error before late rise", 32'(ferr), 32'h0);
      play(1'b0, 1'b0, 768, 384, 768, 24'h333333, 24'h444444, 1'b0);
      check("R8 error after short period", 32'(ferr), 32'h1);
      check("R8 decode resumes after short period", 32'(right), 32'h444444);
      play(1'b1, 1'b1, 768, 384, 768, 24'h555555, 24'h666666, 1'b0);
      check("R8 error is sticky", 32'(ferr), 32'h1);

      // R1 and R8: reset clears the flag; first rise after long idle is exempt
      apply_reset();
      check("R1 left cleared by reset", 32'(left), 32'h0);
      repeat (2000) @(negedge clk);
      play(1'b1, 1'b1, 768, 100, 768, 24'h0ABCDE, 24'hF12345, 1'b0);
      check("R8 first rise not checked", 32'(ferr), 32'h0);
      check("R2 left after reset", 32'(left), 32'h0ABCDE);
      play(1'b0, 1'b0, 768, 600, 768, 24'h7FFFFF, 24'h800000, 1'b1);
      check("R8 second period correct", 32'(ferr), 32'h0);
      check("R3 right extreme code", 32'(right), 32'h800000);

      @(negedge clk);
      wclk = 1'b0;
      repeat (10) @(negedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule